// File: doc/BRIEF.md
# Programmable Host Clock Divider

This block derives a slower host clock from a fast system clock without producing a second clock net. It outputs a one-cycle clock-enable strobe and a square-wave toggle, both timed in the system clock domain. Software writes a 4-bit divisor code. Only the ratios 1, 2, 3, 4, 6, 8 and 12 exist. Any reserved code is mapped to a fixed legal ratio. Both the code as written and the ratio actually in use can be read back.

Software must follow a fixed bring-up sequence:
1. Hold the divider in reset by driving its active-low hold input to 0.
2. Write the divisor code.
3. Read back the code and the ratio.
4. Release the hold and set the enable.

A divisor write made while the divider runs is dropped and raises a sticky error flag. A bypass input turns the enable strobe on for every cycle.

Top module: `host_clk_div`

## Requirements
- R1: The ratio readback `ratio_rd` equals the coerced ratio of the stored code. Codes 0 and 1 give 1, code 2 gives 2, code 3 gives 3, codes 4 and 5 give 4, codes 6 and 7 give 6, codes 8 to 11 give 8, and codes 12 to 15 give 12.
- R2: `code_rd` returns the raw 4-bit code last accepted, including reserved codes. After core reset it is 0.
- R3: A write with `cfg_we`=1 while `div_hold_n`=1 leaves `code_rd` unchanged and sets `wr_err` to 1 from the next cycle on. `wr_err` stays 1 until core reset clears it.
- R4: While `rst_n`=0 or `div_hold_n`=0, `clk_en` and `clk_tog` are 0 and the phase counter returns to 0.
- R5: While `div_en`=0, `clk_en` and `clk_tog` are 0.
- R6: When running with ratio N>1 and no bypass, `clk_en` is 1 in exactly one cycle of every N. The first strobe comes in the first cycle in which hold is released and enable is set together.
- R7: When running with ratio N, `clk_tog` is 1 for the first floor(N/2) cycles of each N-cycle period, starting with the strobe cycle, and 0 for the rest of the period.
- R8: With `div_bypass`=1 while running, `clk_en` is 1 every cycle and `clk_tog` is 0. When bypass drops, the phase restarts at count 0.
- R9: With ratio 1 while running, `clk_en` is 1 every cycle and `clk_tog` is 0.
- R10: A write with `cfg_we`=1 while `div_hold_n`=0 stores `cfg_code`, and `code_rd`/`ratio_rd` show it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| cfg_we | input | 1 | Divisor write strobe |
| cfg_code | input | 4 | Divisor code to write |
| div_hold_n | input | 1 | Divider reset, active low; writes are legal only while 0 |
| div_en | input | 1 | Output generation enable |
| div_bypass | input | 1 | Pass the source rate through undivided |
| code_rd | output | 4 | Stored raw divisor code |
| ratio_rd | output | 4 | Coerced divide ratio in use |
| wr_err | output | 1 | Sticky flag: a write was made while running |
| clk_en | output | 1 | One-cycle enable strobe at the divided rate |
| clk_tog | output | 1 | Divided square wave |

## Verification
The bench writes all sixteen codes. A wrong entry in the coercion table would report an illegal or misplaced ratio, for example 5 instead of 4. Every legal ratio is run for several periods, including the odd ratio 3 and the degenerate ratio 1. An off-by-one counter limit would stretch the period. A wrong high-time rule would give odd ratios the longer half high. The bench also attempts a write while the divider runs, drops hold and enable mid-period, and toggles bypass. A design that accepted the late write would change its period on the fly. A design that failed to restart its phase would place the first strobe late after release.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int CODE_W = 4;

  typedef logic [CODE_W-1:0] code_t;

  // Map any 4-bit code onto the legal ratio set {1,2,3,4,6,8,12}.
  function automatic code_t hcd_coerce(input code_t code);
    code_t r;
    unique case (code)
      4'd0, 4'd1:                 r = 4'd1;
      4'd2:                       r = 4'd2;
      4'd3:                       r = 4'd3;
      4'd4, 4'd5:                 r = 4'd4;
      4'd6, 4'd7:                 r = 4'd6;
      4'd8, 4'd9, 4'd10, 4'd11:   r = 4'd8;
      default:                    r = 4'd12;
    endcase
    return r;
  endfunction

  // Number of high cycles of the toggle output per period: floor(N/2).
  function automatic code_t hcd_high_cycles(input code_t ratio);
    return ratio >> 1;
  endfunction

  // Last counter value in a period.
  function automatic code_t hcd_last_count(input code_t ratio);
    return ratio - code_t'(1);
  endfunction
endpackage

// File: rtl/hcd_code_reg.sv
module hcd_code_reg
  import hcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cfg_we,
  input  code_t cfg_code,
  input  logic  div_hold_n,
  output code_t code_q,
  output code_t ratio,
  output logic  err_q
);
  logic wr_ok;
  logic wr_bad;

  assign wr_ok  = cfg_we && !div_hold_n;
  assign wr_bad = cfg_we && div_hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok)  code_q <= cfg_code;
      if (wr_bad) err_q  <= 1'b1;
    end
  end

  assign ratio = hcd_coerce(code_q);

  // R1
  ratio_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});

  // R3
  late_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> ($stable(code_q) && err_q));

  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R10
  held_write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (code_q == $past(cfg_code)));
endmodule

// File: rtl/hcd_phase.sv
module hcd_phase
  import hcd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  bypass,
  input  code_t ratio,
  output logic  clk_en,
  output logic  clk_tog
);
  code_t cnt_q;
  code_t cnt_d;
  logic  live;
  logic  wrap;
  logic  period_start;

  assign live         = run && !bypass;
  assign wrap         = live && (cnt_q == hcd_last_count(ratio));
  assign period_start = live && (cnt_q == '0);
  assign cnt_d        = (!live || wrap) ? '0 : cnt_q + code_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign clk_en  = run && (bypass || cnt_q == '0);
  assign clk_tog = live && (cnt_q < hcd_high_cycles(ratio));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!clk_en && !clk_tog));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);

  // R6
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && ratio > 4'd1) |=> (!clk_en || bypass));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (cnt_q == '0));
endmodule

// File: rtl/host_clk_div.sv
module host_clk_div
  import hcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_code,
  input  logic       div_hold_n,
  input  logic       div_en,
  input  logic       div_bypass,
  output logic [3:0] code_rd,
  output logic [3:0] ratio_rd,
  output logic       wr_err,
  output logic       clk_en,
  output logic       clk_tog
);
  code_t code_q;
  code_t ratio;
  logic  run;

  assign run = rst_n && div_hold_n && div_en;

  hcd_code_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_code  (cfg_code),
    .div_hold_n(div_hold_n),
    .code_q    (code_q),
    .ratio     (ratio),
    .err_q     (wr_err)
  );

  hcd_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .bypass (div_bypass),
    .ratio  (ratio),
    .clk_en (clk_en),
    .clk_tog(clk_tog)
  );

  assign code_rd  = code_q;
  assign ratio_rd = ratio;

  // R8
  bypass_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_bypass) |-> (clk_en && !clk_tog));

  // R5
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_en |-> (!clk_en && !clk_tog));
endmodule

// File: tb/host_clk_div_test.sv
module host_clk_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_code = 4'd0;
  logic       div_hold_n = 1'b0;
  logic       div_en = 1'b0;
  logic       div_bypass = 1'b0;
  logic [3:0] code_rd;
  logic [3:0] ratio_rd;
  logic       wr_err;
  logic       clk_en;
  logic       clk_tog;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic en;
    logic tog;
    int   req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  host_clk_div uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .div_hold_n(div_hold_n), .div_en(div_en), .div_bypass(div_bypass),
    .code_rd(code_rd), .ratio_rd(ratio_rd), .wr_err(wr_err),
    .clk_en(clk_en), .clk_tog(clk_tog)
  );

  function automatic int exp_ratio(int c);
    if (c <= 1)  return 1;
    if (c <= 3)  return c;
    if (c <= 5)  return 4;
    if (c <= 7)  return 6;
    if (c <= 11) return 8;
    return 12;
  endfunction

  task automatic chk(bit ok, int req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compare outputs against the scoreboard at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(clk_en === e.en, e.req, "clk_en", int'(clk_en), int'(e.en));
      chk(clk_tog === e.tog, e.req, "clk_tog", int'(clk_tog), int'(e.tog));
    end
  end

  task automatic step(logic en, logic tog, int req);
    sb.push_back('{en: en, tog: tog, req: req});
    @(posedge clk); #1;
  endtask

  // R6 R7 R9: expected stream for ratio n, starting at phase k0
  task automatic run_period(int n, int cyc, int k0, int req);
    for (int k = k0; k < k0 + cyc; k++) begin
      int ph = k % n;
      step(ph == 0, ph < (n / 2), req);
    end
  endtask

  task automatic write_code(int c);
    cfg_code = 4'(c);
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    int ratios[7] = '{2, 3, 4, 6, 8, 12, 1};
    #30000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int ratios[7] = '{2, 3, 4, 6, 8, 12, 1};
    div_en = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R4 R2: reset state
    step(1'b0, 1'b0, 4);
    chk(code_rd == 4'd0, 2, "code after reset", code_rd, 0);
    chk(ratio_rd == 4'd1, 1, "ratio after reset", ratio_rd, 1);
    chk(wr_err == 1'b0, 3, "err after reset", wr_err, 0);

    rst_n = 1'b1;
    step(1'b0, 1'b0, 4);
    // R1 R2 R10: every code, written while held
    for (int c = 0; c < 16; c++) begin
      write_code(c);
      chk(code_rd == 4'(c), 10, "code readback", code_rd, c);
      chk(int'(ratio_rd) == exp_ratio(c), 1, "coerced ratio", ratio_rd, exp_ratio(c));
      step(1'b0, 1'b0, 4);
    end
    chk(wr_err == 1'b0, 3, "err after held writes", wr_err, 0);

    // R6 R7 R9: each legal ratio from release
    foreach (ratios[i]) begin
      div_hold_n = 1'b0;
      write_code(ratios[i]);
      step(1'b0, 1'b0, 4);
      div_hold_n = 1'b1;
      run_period(ratios[i], 3 * ratios[i] + 1, 0, (ratios[i] == 1) ? 9 : 6);
    end

    // R4: hold mid-period then restart
    div_hold_n = 1'b0;
    write_code(6);
    div_hold_n = 1'b1;
    run_period(6, 4, 0, 7);
    div_hold_n = 1'b0;
    step(1'b0, 1'b0, 4);
    step(1'b0, 1'b0, 4);
    div_hold_n = 1'b1;
    run_period(6, 7, 0, 4);

    // R3: write while running is ignored
    div_hold_n = 1'b0;
    write_code(3);
    div_hold_n = 1'b1;
    run_period(3, 3, 0, 6);
    cfg_code = 4'd8;
    cfg_we = 1'b1;
    run_period(3, 1, 3, 3);
    cfg_we = 1'b0;
    chk(code_rd == 4'd3, 3, "code after late write", code_rd, 3);
    chk(ratio_rd == 4'd3, 3, "ratio after late write", ratio_rd, 3);
    chk(wr_err == 1'b1, 3, "err after late write", wr_err, 1);
    run_period(3, 6, 4, 3);
    div_hold_n = 1'b0;
    step(1'b0, 1'b0, 4);
    chk(wr_err == 1'b1, 3, "err sticky", wr_err, 1);
    div_hold_n = 1'b1;

    // R5: enable low silences outputs, restart on raise
    div_en = 1'b0;
    repeat (3) step(1'b0, 1'b0, 5);
    div_en = 1'b1;
    run_period(3, 6, 0, 5);

    // R8: bypass
    div_hold_n = 1'b0;
    write_code(4);
    div_hold_n = 1'b1;
    run_period(4, 2, 0, 7);
    div_bypass = 1'b1;
    repeat (5) step(1'b1, 1'b0, 8);
    div_bypass = 1'b0;
    run_period(4, 8, 0, 8);

    // R4 R3: core reset mid-run clears everything
    rst_n = 1'b0;
    step(1'b0, 1'b0, 4);
    step(1'b0, 1'b0, 4);
    chk(code_rd == 4'd0, 4, "code after core reset", code_rd, 0);
    chk(wr_err == 1'b0, 3, "err after core reset", wr_err, 0);
    rst_n = 1'b1;
    run_period(1, 3, 0, 9);

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule